// File: doc/BRIEF.md
# Dual Compare/Capture Timer Channel

This block is one channel of a 16-bit timer. An external free-running counter supplies its value and a clock-enable qualifier. The channel holds two units, A and B, each built around a 16-bit register. In comparator mode a unit watches for the counter to equal its register and raises a one-cycle match strobe. The compare events of both units shape two waveform outputs, each with its own mode and polarity, which can form PWM signals. In capture mode a unit instead stores the counter value when a chosen edge arrives on its external capture input. It also sets a sticky flag that software clears.

Software reaches the channel through a small register port with a 2-bit address. Address 0 holds the 16-bit control word, 1 is unit A's register, 2 is unit B's register, and 3 is the capture flag word. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `cct_chan`

## Requirements
- R1: After reset the control word, both unit registers, both capture flags, both match strobes and both outputs are 0.
- R2: The control word is laid out per unit: unit A uses bits 7:0 and unit B bits 15:8, with the same sub-layout. Bit 0 of the unit byte selects the mode (1 capture, 0 compare). Bit 1 is output invert. Bits 5:4 are the output mode. Bits 7:6 are the capture trigger. Bits 3:2 and 11:10 are reserved and read back as 0.
- R3: A unit in comparator mode produces a match strobe that is high for exactly the one cycle after an edge where `cnt_en` was 1 and `cnt_val` equalled its register. There is no strobe when `cnt_en` is 0.
- R4: Output mode 1 drives the output active on a compare A event and inactive on a compare B event. When both events occur on the same edge, the output goes inactive.
- R5: Output mode 2 toggles the output on each compare A event and ignores compare B.
- R6: Output mode 3 toggles the output on each compare B event and ignores compare A.
- R7: Invert bit 0 makes the output active high, with an off level of low. Invert bit 1 makes it active low, with an off level of high. Output mode 0 holds the off level.
- R8: In capture mode the trigger field selects when the counter value is stored in the unit register: 0 never, 1 rising edge, 2 falling edge, 3 both edges. Capture inputs pass through a two-stage synchronizer first.
- R9: Each capture sets a sticky flag. The flags read at address 3, with bit 0 for unit A and bit 1 for unit B. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: A unit in comparator mode ignores edges on its capture input. Its register and flag stay unchanged.
- R11: While a unit is in capture mode it never strobes a match, and its output is held low whatever its output mode and invert bits are.
- R12: The unit registers are read and written at addresses 1 (A) and 2 (B). The control word is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cnt_val | input | 16 | Counter value |
| cnt_en | input | 1 | Counter clock-enable qualifier |
| cap_in_a | input | 1 | External capture input, unit A |
| cap_in_b | input | 1 | External capture input, unit B |
| match_a | output | 1 | Compare A match strobe |
| match_b | output | 1 | Compare B match strobe |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
The bench targets an edge in mode 1 where both compares fire together. A design that lets the set event win would leave the output stuck active for a whole period. Capture is exercised with each trigger code and with the wrong-polarity edge, which catches swapped rise/fall decoding. The bench also checks edges on a unit in comparator mode, which a design that does not gate capture by mode would store. Writes of all ones to the control word and write-1-to-clear writes with mixed bits expose reserved bits that leak and flags that clear the wrong unit. An inverted, enabled output in capture mode exposes a design that forgets to override the polarity.

// File: rtl/cct_pkg.sv
package cct_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_REGA = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_REGB = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd3;

  localparam int CTRL_W = 16;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hF3F3;

  typedef enum logic [1:0] {
    WM_OFF    = 2'd0,
    WM_SETCLR = 2'd1,
    WM_TOG_A  = 2'd2,
    WM_TOG_B  = 2'd3
  } wave_mode_e;

  // Trigger code: 0 never, 1 rising, 2 falling, 3 both
  function automatic logic edge_hit(input logic [1:0] trig, input logic rise, input logic fall);
    return (trig[0] & rise) | (trig[1] & fall);
  endfunction

  // Next waveform state (1 = active); compare B has priority in set/clear mode
  function automatic logic wave_next(input wave_mode_e m, input logic st,
                                     input logic ev_a, input logic ev_b);
    case (m)
      WM_SETCLR: return ev_b ? 1'b0 : (ev_a ? 1'b1 : st);
      WM_TOG_A:  return ev_a ? ~st : st;
      WM_TOG_B:  return ev_b ? ~st : st;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic rise,
  output logic fall
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[TOP];

  assign rise = sh_q[TOP] & ~prev_q;
  assign fall = ~sh_q[TOP] & prev_q;

endmodule

// File: rtl/cct_unit.sv
module cct_unit
  import cct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mode,
  input  logic [1:0]   trig,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_en,
  input  logic         wr_reg,
  input  logic [W-1:0] wr_data,
  input  logic         clr_flag,
  input  logic         rise,
  input  logic         fall,
  output logic [W-1:0] reg_q,
  output logic         flag_q,
  output logic         cmp_ev,
  output logic         match_q
);
  logic cap_ev;

  assign cap_ev = cap_mode & edge_hit(trig, rise, fall);
  assign cmp_ev = ~cap_mode & cnt_en & (cnt_val == reg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= '0;
      flag_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= cmp_ev;
      if (cap_ev)      reg_q <= cnt_val;
      else if (wr_reg) reg_q <= wr_data;
      if (cap_ev)        flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  assert_capture_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (reg_q == $past(cnt_val)));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_flag) |=> flag_q);

  assert_no_match_in_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode |=> !match_q);

endmodule

// File: rtl/cct_wave.sv
module cct_wave
  import cct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       inv,
  input  logic       ev_a,
  input  logic       ev_b,
  output logic       wave_o
);
  wave_mode_e m;
  logic       st_q;
  logic       live;

  assign m    = wave_mode_e'(mode);
  assign live = en & (m != WM_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= 1'b0;
    else if (!live) st_q <= 1'b0;
    else            st_q <= wave_next(m, st_q, ev_a, ev_b);
  end

  assign wave_o = en ? (inv ^ (st_q & live)) : 1'b0;

  assert_tie_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && m == WM_SETCLR && ev_a && ev_b) |=> !st_q);

  assert_toggle_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && m == WM_TOG_A && ev_a) |=> (st_q != $past(st_q)));

  assert_toggle_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && m == WM_TOG_B && ev_b) |=> (st_q != $past(st_q)));

endmodule

// File: rtl/cct_chan.sv
module cct_chan
  import cct_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      cnt_val,
  input  logic              cnt_en,
  input  logic              cap_in_a,
  input  logic              cap_in_b,
  output logic              match_a,
  output logic              match_b,
  output logic              out_a,
  output logic              out_b
);
  localparam int NU = 2;
  localparam int UB = CTRL_W / NU;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NU-1:0]     cap_in, rise, fall, flag, cmp_ev, match, wave;
  logic [W-1:0]      reg_q [NU];

  assign cap_in = {cap_in_b, cap_in_a};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             ctrl_q <= '0;
    else if (wr_en && wr_addr == ADR_CTRL)  ctrl_q <= CTRL_W'(wr_data) & CTRL_MASK;

  generate
    for (genvar g = 0; g < NU; g++) begin : g_unit
      logic [UB-1:0] cfg;
      logic          wr_sel;
      assign cfg    = ctrl_q[g*UB +: UB];
      assign wr_sel = wr_en && (wr_addr == ADDR_W'(ADR_REGA + g));

      cct_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(cap_in[g]),
        .rise(rise[g]), .fall(fall[g]));

      cct_unit #(.W(W)) u_unit (
        .clk(clk), .rst_n(rst_n),
        .cap_mode(cfg[0]), .trig(cfg[7:6]),
        .cnt_val(cnt_val), .cnt_en(cnt_en),
        .wr_reg(wr_sel), .wr_data(wr_data),
        .clr_flag(wr_en && wr_addr == ADR_FLAG && wr_data[g]),
        .rise(rise[g]), .fall(fall[g]),
        .reg_q(reg_q[g]), .flag_q(flag[g]),
        .cmp_ev(cmp_ev[g]), .match_q(match[g]));

      cct_wave u_wave (
        .clk(clk), .rst_n(rst_n),
        .en(~cfg[0]), .mode(cfg[5:4]), .inv(cfg[1]),
        .ev_a(cmp_ev[0]), .ev_b(cmp_ev[1]),
        .wave_o(wave[g]));
    end
  endgenerate

  always_comb begin
    case (rd_addr)
      ADR_CTRL: rd_data = W'(ctrl_q);
      ADR_REGA: rd_data = reg_q[0];
      ADR_REGB: rd_data = reg_q[1];
      default:  rd_data = W'(flag);
    endcase
  end

  assign match_a = match[0];
  assign match_b = match[1];
  assign out_a   = wave[0];
  assign out_b   = wave[1];

  assert_reserved_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CTRL) |=> (ctrl_q[3:2] == 2'b00 && ctrl_q[11:10] == 2'b00));

  assert_strobe_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (!match_a && !match_b));

endmodule

// File: tb/sim_cct_chan.sv
module sim_cct_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] cnt_val = '0;
  logic        cnt_en = 1'b0;
  logic        cap_in_a = 1'b0;
  logic        cap_in_b = 1'b0;
  logic        match_a, match_b, out_a, out_b;

  int vectors = 0;
  int fails = 0;

  cct_chan u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic step(input logic [15:0] cv, input logic en);
    cnt_val = cv; cnt_en = en;
    @(posedge clk); @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); end
    @(negedge clk);
  endtask

  task automatic quiet_waves();
    wr(2'd0, 16'h0000);
    step(16'hFFFF, 1'b0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reset register", d, 16'h0000);
    end
    chk("R1 reset outputs", {12'h0, match_a, match_b, out_a, out_b}, 16'h0000);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R2 reserved bits read 0", d, 16'hF3F3);
    wr(2'd0, 16'h4281);
    rd(2'd0, d); chk("R2 control readback", d, 16'h4281);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'h0020);
    rd(2'd1, d); chk("R12 register A at address 1", d, 16'h0010);
    rd(2'd2, d); chk("R12 register B at address 2", d, 16'h0020);
  endtask

  task automatic t_match();
    step(16'h0010, 1'b1);
    chk("R3 strobe A on equal", {15'h0, match_a}, 16'h1);
    chk("R3 no strobe B", {15'h0, match_b}, 16'h0);
    step(16'h0011, 1'b1);
    chk("R3 strobe lasts one cycle", {15'h0, match_a}, 16'h0);
    step(16'h0010, 1'b0);
    chk("R3 no strobe without enable", {15'h0, match_a}, 16'h0);
    step(16'h0020, 1'b1);
    chk("R3 strobe B on equal", {14'h0, match_a, match_b}, 16'h1);
  endtask

  task automatic t_setclr();
    quiet_waves();
    wr(2'd0, 16'h0010);
    chk("R4 starts inactive", {15'h0, out_a}, 16'h0);
    step(16'h0010, 1'b1); chk("R4 set on compare A", {15'h0, out_a}, 16'h1);
    step(16'h0015, 1'b1); chk("R4 holds between events", {15'h0, out_a}, 16'h1);
    step(16'h0020, 1'b1); chk("R4 clear on compare B", {15'h0, out_a}, 16'h0);
    step(16'h0010, 1'b1); chk("R4 set again", {15'h0, out_a}, 16'h1);
    wr(2'd2, 16'h0010);
    step(16'h0010, 1'b1); chk("R4 tie goes inactive", {15'h0, out_a}, 16'h0);
    wr(2'd2, 16'h0020);
  endtask

  task automatic t_tog_a();
    quiet_waves();
    wr(2'd0, 16'h0020);
    step(16'h0010, 1'b1); chk("R5 toggle on A", {15'h0, out_a}, 16'h1);
    step(16'h0020, 1'b1); chk("R5 B ignored", {15'h0, out_a}, 16'h1);
    step(16'h0010, 1'b1); chk("R5 toggle back", {15'h0, out_a}, 16'h0);
  endtask

  task automatic t_tog_b();
    quiet_waves();
    wr(2'd0, 16'h3000);
    step(16'h0020, 1'b1); chk("R6 toggle on B", {15'h0, out_b}, 16'h1);
    step(16'h0010, 1'b1); chk("R6 A ignored", {15'h0, out_b}, 16'h1);
    step(16'h0020, 1'b1); chk("R6 toggle back", {15'h0, out_b}, 16'h0);
    chk("R6 output A off", {15'h0, out_a}, 16'h0);
  endtask

  task automatic t_invert();
    quiet_waves();
    chk("R7 off level low", {14'h0, out_a, out_b}, 16'h0);
    wr(2'd0, 16'h0002);
    chk("R7 off level high when inverted", {14'h0, out_a, out_b}, 16'h2);
    wr(2'd0, 16'h0012);
    step(16'h0010, 1'b1); chk("R7 active low", {15'h0, out_a}, 16'h0);
    step(16'h0020, 1'b1); chk("R7 inactive high", {15'h0, out_a}, 16'h1);
    wr(2'd0, 16'h0200);
    chk("R7 invert B off level", {14'h0, out_a, out_b}, 16'h1);
  endtask

  task automatic capa(input logic [15:0] cv, input logic lvl);
    cnt_val = cv; cap_in_a = lvl; idle(5);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    quiet_waves();
    wr(2'd0, 16'h0041);
    capa(16'h1234, 1'b1);
    rd(2'd1, d); chk("R8 rising capture", d, 16'h1234);
    rd(2'd3, d); chk("R9 flag A set", d, 16'h0001);
    capa(16'h2222, 1'b0);
    rd(2'd1, d); chk("R8 falling ignored in rising mode", d, 16'h1234);
    wr(2'd0, 16'h0081);
    capa(16'h3333, 1'b1);
    rd(2'd1, d); chk("R8 rising ignored in falling mode", d, 16'h1234);
    capa(16'h3334, 1'b0);
    rd(2'd1, d); chk("R8 falling capture", d, 16'h3334);
    wr(2'd0, 16'h00C1);
    capa(16'h4444, 1'b1);
    rd(2'd1, d); chk("R8 both: rising", d, 16'h4444);
    capa(16'h5555, 1'b0);
    rd(2'd1, d); chk("R8 both: falling", d, 16'h5555);
    wr(2'd0, 16'h0001);
    capa(16'h6666, 1'b1);
    capa(16'h6667, 1'b0);
    rd(2'd1, d); chk("R8 never trigger", d, 16'h5555);
    wr(2'd0, 16'h4100);
    cnt_val = 16'h7777; cap_in_b = 1'b1; idle(5);
    rd(2'd2, d); chk("R8 unit B rising capture", d, 16'h7777);
    rd(2'd3, d); chk("R9 both flags set", d, 16'h0003);
    cap_in_b = 1'b0; idle(5);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    wr(2'd3, 16'h0000);
    rd(2'd3, d); chk("R9 write 0 keeps flags", d, 16'h0003);
    wr(2'd3, 16'h0001);
    rd(2'd3, d); chk("R9 clear A only", d, 16'h0002);
    wr(2'd3, 16'h0002);
    rd(2'd3, d); chk("R9 clear B", d, 16'h0000);
  endtask

  task automatic t_cmp_ignores_cap();
    logic [15:0] d;
    wr(2'd0, 16'h00C0);
    wr(2'd1, 16'h0ABC);
    capa(16'h9999, 1'b1);
    capa(16'h9998, 1'b0);
    rd(2'd1, d); chk("R10 register unchanged in compare mode", d, 16'h0ABC);
    rd(2'd3, d); chk("R10 flag unchanged in compare mode", d, 16'h0000);
  endtask

  task automatic t_cap_output();
    wr(2'd0, 16'h0013);
    chk("R11 output low despite invert", {15'h0, out_a}, 16'h0);
    wr(2'd1, 16'h0ABC);
    step(16'h0ABC, 1'b1);
    chk("R11 no strobe in capture mode", {15'h0, match_a}, 16'h0);
    chk("R11 output stays low", {15'h0, out_a}, 16'h0);
    wr(2'd0, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_ctrl();
    t_regs();
    t_match();
    t_setclr();
    t_tog_a();
    t_tog_b();
    t_invert();
    t_capture();
    t_flags();
    t_cmp_ignores_cap();
    t_cap_output();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule